// File: doc/BRIEF.md
# Time-of-Day and Calendar Counter with Update Sequencing

This block keeps wall-clock time and date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A once-per-second strobe from an external prescaler asks for an advance. The block raises a busy flag, waits a fixed lead time, moves every field forward by one second with all carries applied, then holds the busy flag for a fixed tail before it drops. On that falling edge it emits an update-done pulse. In the same cycle it emits an alarm pulse if seconds, minutes and hours match their alarm registers.

Each field is held either as packed BCD or as plain binary. Hours run either as 0–23 or as 1–12 with a PM flag in bit 7. A control bit lets the host freeze advances while it loads a new time. Host access is a simple byte-wide register port. Writes take effect on the clock edge. Reads return data one cycle after the address is presented.

Top module: `rtc_calendar`

## Requirements
- R1: After synchronous reset, seconds, minutes, hours, year and all alarm registers read 0x00. Day of week, day of month and month read 0x01. The control register reads 0x02, which selects BCD and 24-hour mode. The status register reads 0x00.
- R2: With control bit 2 clear, every time and date field counts in packed BCD: tens in bits 7:4 and units in bits 3:0. Carries go from seconds to minutes, from minutes to hours and so on up the fields.
- R3: With control bit 2 set, every field counts in plain binary, with the same ranges and carries.
- R4: With control bit 1 set, hours run 0–23 and wrap to 0. With it clear, hours run 1–12 and bit 7 set means PM. 11 AM advances to 12 PM, 11 PM advances to 12 AM, and 12 advances to 1 with the PM flag kept.
- R5: Day of week runs 1–7 and wraps to 1. Day of month wraps to 1 after the last day of the month: 30 for April, June, September and November, 31 for the other months except February. February has 29 days when the year is a multiple of four and 28 otherwise. Month wraps from 12 to 1, and year wraps from 99 to 0.
- R6: While control bit 7 (freeze) is set, a second strobe starts no update. The busy flag stays low and no field changes.
- R7: A strobe accepted while idle raises the busy flag at the next edge, which is cycle 0. The time fields change at cycle LEAD_CYC. The busy flag stays high for LEAD_CYC+TAIL_CYC cycles (8+57 by default). Strobes that arrive while busy are ignored.
- R8: The update-done output is high for exactly one cycle per update. That cycle is the first cycle after the busy flag falls.
- R9: The alarm output pulses together with update-done when the new seconds, minutes and hours equal the alarm registers at addresses 1, 3 and 5. An alarm byte of 0xC0–0xFF matches any value of its field.
- R10: While the busy flag is high, writes to addresses 0–9 are ignored. Writes to the control register are still accepted.
- R11: The read map is as follows. Addresses 0, 2, 4, 6, 7, 8 and 9 hold seconds, minutes, hours, day of week, day of month, month and year. Address 10 returns the busy flag in bit 7 with the other bits 0. Address 11 returns the control register, with only bits 7, 2 and 1 stored and the rest reading 0. Addresses 12–15 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle once-per-second advance request |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Read data, one cycle after address |
| uip_o | output | 1 | Update busy flag |
| done_o | output | 1 | One-cycle update-done pulse |
| alarm_o | output | 1 | One-cycle alarm-match pulse |

## Verification
The bench targets the cascaded carries, which are the most likely place for a design to go wrong. It covers year-end rollover, non-leap and leap Februaries, a 30-day month, and 12-hour noon and midnight. A design with a wrong month length or leap test would land on the wrong date. A design that swaps the AM/PM transitions would show 12 with the wrong flag. The bench also measures the exact cycle at which the seconds change and how long the busy flag stays up, so an off-by-one in the sequencer moves the observed edge. Further tests cover strobes while frozen or busy, writes during busy, and alarm match, mismatch and don't-care cases. These would expose a design that advances twice, lets a host write corrupt an update, or pulses the alarm at the wrong time.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NUM_TM  = 10;
  localparam int IX_SEC  = 0;
  localparam int IX_ASEC = 1;
  localparam int IX_MIN  = 2;
  localparam int IX_AMIN = 3;
  localparam int IX_HR   = 4;
  localparam int IX_AHR  = 5;
  localparam int IX_DOW  = 6;
  localparam int IX_DOM  = 7;
  localparam int IX_MON  = 8;
  localparam int IX_YR   = 9;
  localparam int IX_STAT = 10;
  localparam int IX_CTL  = 11;

  // field value in stored format -> binary
  function automatic logic [7:0] f2b(input logic [7:0] v, input logic bin);
    if (bin) return v;
    return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
  endfunction

  // binary (0..99) -> stored format
  function automatic logic [7:0] b2f(input logic [7:0] b, input logic bin);
    logic [7:0] tens, ones;
    if (bin) return b;
    tens = b / 8'd10;
    ones = b % 8'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  // stored hour -> binary 0..23
  function automatic logic [7:0] hr_to24(input logic [7:0] raw, input logic bin,
                                         input logic h24);
    logic [7:0] h12;
    if (h24) return f2b(raw, bin);
    h12 = f2b({1'b0, raw[6:0]}, bin);
    if (h12 == 8'd12) return raw[7] ? 8'd12 : 8'd0;
    return raw[7] ? h12 + 8'd12 : h12;
  endfunction

  // binary 0..23 -> stored hour
  function automatic logic [7:0] hr_from24(input logic [7:0] h, input logic bin,
                                           input logic h24);
    logic [7:0] h12, enc;
    logic       pm;
    if (h24) return b2f(h, bin);
    pm  = (h >= 8'd12);
    h12 = pm ? h - 8'd12 : h;
    if (h12 == 8'd0) h12 = 8'd12;
    enc = b2f(h12, bin);
    return {pm, enc[6:0]};
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd2:                        return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:     return 8'd30;
      default:                     return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_seq.sv
module rtc_cal_seq #(
  parameter int LEAD_CYC = 8,
  parameter int TAIL_CYC = 57
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic inhibit_i,
  output logic busy_o,
  output logic adv_o,
  output logic end_o
);
  localparam int TOTAL = LEAD_CYC + TAIL_CYC;
  localparam int CW    = $clog2(TOTAL + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (tick_i && !inhibit_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(1);
      end
    end else if (cnt_q == CW'(TOTAL)) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign busy_o = busy_q;
  assign adv_o  = busy_q && (cnt_q == CW'(LEAD_CYC));
  assign end_o  = busy_q && (cnt_q == CW'(TOTAL));

endmodule

// File: rtl/rtc_cal_next.sv
module rtc_cal_next
  import rtc_cal_pkg::*;
(
  input  logic       bin_i,
  input  logic       h24_i,
  input  logic [7:0] sec_i,
  input  logic [7:0] min_i,
  input  logic [7:0] hr_i,
  input  logic [7:0] dow_i,
  input  logic [7:0] dom_i,
  input  logic [7:0] mon_i,
  input  logic [7:0] yr_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hr_o,
  output logic [7:0] dow_o,
  output logic [7:0] dom_o,
  output logic [7:0] mon_o,
  output logic [7:0] yr_o
);
  logic [7:0] s_b, m_b, h_b, w_b, d_b, mo_b, y_b, mlen;
  logic [7:0] s_n, m_n, h_n, w_n, d_n, mo_n, y_n;
  logic       c_s, c_m, c_h, c_d, c_mo;

  always_comb begin
    s_b  = f2b(sec_i, bin_i);
    m_b  = f2b(min_i, bin_i);
    h_b  = hr_to24(hr_i, bin_i, h24_i);
    w_b  = f2b(dow_i, bin_i);
    d_b  = f2b(dom_i, bin_i);
    mo_b = f2b(mon_i, bin_i);
    y_b  = f2b(yr_i, bin_i);
    mlen = month_days(mo_b, y_b);

    c_s = (s_b >= 8'd59);
    s_n = c_s ? 8'd0 : s_b + 8'd1;

    c_m = c_s && (m_b >= 8'd59);
    m_n = c_s ? (c_m ? 8'd0 : m_b + 8'd1) : m_b;

    c_h = c_m && (h_b >= 8'd23);
    h_n = c_m ? (c_h ? 8'd0 : h_b + 8'd1) : h_b;

    w_n = c_h ? ((w_b >= 8'd7) ? 8'd1 : w_b + 8'd1) : w_b;

    c_d = c_h && (d_b >= mlen);
    d_n = c_h ? (c_d ? 8'd1 : d_b + 8'd1) : d_b;

    c_mo = c_d && (mo_b >= 8'd12);
    mo_n = c_d ? (c_mo ? 8'd1 : mo_b + 8'd1) : mo_b;

    y_n = c_mo ? ((y_b >= 8'd99) ? 8'd0 : y_b + 8'd1) : y_b;

    sec_o = b2f(s_n, bin_i);
    min_o = b2f(m_n, bin_i);
    hr_o  = hr_from24(h_n, bin_i, h24_i);
    dow_o = b2f(w_n, bin_i);
    dom_o = b2f(d_n, bin_i);
    mon_o = b2f(mo_n, bin_i);
    yr_o  = b2f(y_n, bin_i);
  end

endmodule

// File: rtl/rtc_cal_alarm.sv
module rtc_cal_alarm #(
  parameter int NFIELD = 3
) (
  input  logic [NFIELD-1:0][7:0] cur_i,
  input  logic [NFIELD-1:0][7:0] ref_i,
  output logic                   match_o
);
  logic [NFIELD-1:0] hit;

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    assign hit[g] = (ref_i[g][7:6] == 2'b11) || (ref_i[g] == cur_i[g]);
  end

  assign match_o = &hit;

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int LEAD_CYC = 8,
  parameter int TAIL_CYC = 57
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              uip_o,
  output logic              done_o,
  output logic              alarm_o
);
  logic [7:0] tm_q [NUM_TM];
  logic       ctl_set_q, ctl_bin_q, ctl_h24_q;
  logic       busy, adv, fin, match;
  logic [7:0] n_sec, n_min, n_hr, n_dow, n_dom, n_mon, n_yr;
  logic [7:0] rd_q;
  logic       done_q, alarm_q;

  rtc_cal_seq #(.LEAD_CYC(LEAD_CYC), .TAIL_CYC(TAIL_CYC)) u_seq (
    .clk(clk), .rst(rst), .tick_i(tick_i), .inhibit_i(ctl_set_q),
    .busy_o(busy), .adv_o(adv), .end_o(fin)
  );

  rtc_cal_next u_next (
    .bin_i(ctl_bin_q), .h24_i(ctl_h24_q),
    .sec_i(tm_q[IX_SEC]), .min_i(tm_q[IX_MIN]), .hr_i(tm_q[IX_HR]),
    .dow_i(tm_q[IX_DOW]), .dom_i(tm_q[IX_DOM]), .mon_i(tm_q[IX_MON]),
    .yr_i(tm_q[IX_YR]),
    .sec_o(n_sec), .min_o(n_min), .hr_o(n_hr), .dow_o(n_dow),
    .dom_o(n_dom), .mon_o(n_mon), .yr_o(n_yr)
  );

  rtc_cal_alarm #(.NFIELD(3)) u_alarm (
    .cur_i({tm_q[IX_HR], tm_q[IX_MIN], tm_q[IX_SEC]}),
    .ref_i({tm_q[IX_AHR], tm_q[IX_AMIN], tm_q[IX_ASEC]}),
    .match_o(match)
  );

  // time, date and alarm storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_TM; i++) tm_q[i] <= 8'h00;
      tm_q[IX_DOW] <= 8'h01;
      tm_q[IX_DOM] <= 8'h01;
      tm_q[IX_MON] <= 8'h01;
    end else if (adv) begin
      tm_q[IX_SEC] <= n_sec;
      tm_q[IX_MIN] <= n_min;
      tm_q[IX_HR]  <= n_hr;
      tm_q[IX_DOW] <= n_dow;
      tm_q[IX_DOM] <= n_dom;
      tm_q[IX_MON] <= n_mon;
      tm_q[IX_YR]  <= n_yr;
    end else if (wr_en_i && !busy && (wr_addr_i < ADDR_W'(NUM_TM))) begin
      tm_q[wr_addr_i] <= wr_data_i;
    end
  end

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_set_q <= 1'b0;
      ctl_bin_q <= 1'b0;
      ctl_h24_q <= 1'b1;
    end else if (wr_en_i && (wr_addr_i == ADDR_W'(IX_CTL))) begin
      ctl_set_q <= wr_data_i[7];
      ctl_bin_q <= wr_data_i[2];
      ctl_h24_q <= wr_data_i[1];
    end
  end

  // registered read port and pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= 8'h00;
      done_q  <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      done_q  <= fin;
      alarm_q <= fin && match;
      if (rd_addr_i < ADDR_W'(NUM_TM))
        rd_q <= tm_q[rd_addr_i];
      else if (rd_addr_i == ADDR_W'(IX_STAT))
        rd_q <= {busy, 7'b0};
      else if (rd_addr_i == ADDR_W'(IX_CTL))
        rd_q <= {ctl_set_q, 4'b0, ctl_bin_q, ctl_h24_q, 1'b0};
      else
        rd_q <= 8'h00;
    end
  end

  assign rd_data_o = rd_q;
  assign uip_o     = busy;
  assign done_o    = done_q;
  assign alarm_o   = alarm_q;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int LEAD_CYC = 8,
  parameter int TAIL_CYC = 57
) (
  input logic clk,
  input logic rst,
  input logic tick_i,
  input logic set_mode,
  input logic uip_o,
  input logic done_o,
  input logic alarm_o
);
  localparam int TOTAL = LEAD_CYC + TAIL_CYC;
  localparam int CW    = $clog2(TOTAL + 2);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)        hi_cnt <= '0;
    else if (uip_o) hi_cnt <= hi_cnt + CW'(1);
    else            hi_cnt <= '0;
  end

  // R7: busy never lasts longer than the full update window
  a_r7_uip_bound: assert property (@(posedge clk) disable iff (rst)
    uip_o |-> (hi_cnt < CW'(TOTAL)));

  // R8: done appears only as busy falls
  a_r8_done_on_fall: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $fell(uip_o));

  // R8: every busy fall gives a done pulse
  a_r8_fall_gives_done: assert property (@(posedge clk) disable iff (rst)
    $fell(uip_o) |-> done_o);

  // R8: done is a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9: alarm only with done
  a_r9_alarm_with_done: assert property (@(posedge clk) disable iff (rst)
    alarm_o |-> done_o);

  // R6: freeze blocks update start
  a_r6_freeze_blocks: assert property (@(posedge clk) disable iff (rst)
    (set_mode && !uip_o && tick_i) |=> !uip_o);

endmodule

bind rtc_calendar rtc_calendar_chk #(.LEAD_CYC(LEAD_CYC), .TAIL_CYC(TAIL_CYC)) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .set_mode(ctl_set_q),
  .uip_o(uip_o), .done_o(done_o), .alarm_o(alarm_o)
);

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
  localparam int LEAD  = 8;
  localparam int TAIL  = 57;
  localparam int TOTAL = LEAD + TAIL;
  localparam int NV    = 11;

  // {ctrl, sec,min,hr,dow,dom,mon,yr, exp sec,min,hr,dow,dom,mon,yr}
  localparam logic [119:0] VEC [NV] = '{
    {8'h02, 8'h59,8'h59,8'h23,8'h07,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00},
    {8'h02, 8'h59,8'h59,8'h23,8'h03,8'h28,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h04,8'h01,8'h03,8'h23},
    {8'h02, 8'h59,8'h59,8'h23,8'h03,8'h28,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h04,8'h29,8'h02,8'h24},
    {8'h02, 8'h59,8'h59,8'h23,8'h02,8'h29,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h03,8'h24},
    {8'h00, 8'h59,8'h59,8'h11,8'h02,8'h15,8'h06,8'h10, 8'h00,8'h00,8'h92,8'h02,8'h15,8'h06,8'h10},
    {8'h00, 8'h59,8'h59,8'h91,8'h05,8'h30,8'h04,8'h10, 8'h00,8'h00,8'h12,8'h06,8'h01,8'h05,8'h10},
    {8'h00, 8'h59,8'h59,8'h12,8'h01,8'h01,8'h01,8'h00, 8'h00,8'h00,8'h01,8'h01,8'h01,8'h01,8'h00},
    {8'h06, 8'h3B,8'h3B,8'h17,8'h01,8'h1E,8'h06,8'h0A, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h07,8'h0A},
    {8'h04, 8'h3B,8'h3B,8'h8C,8'h04,8'h0A,8'h03,8'h05, 8'h00,8'h00,8'h81,8'h04,8'h0A,8'h03,8'h05},
    {8'h02, 8'h09,8'h45,8'h10,8'h01,8'h01,8'h01,8'h00, 8'h10,8'h45,8'h10,8'h01,8'h01,8'h01,8'h00},
    {8'h06, 8'h09,8'h2D,8'h0A,8'h01,8'h01,8'h01,8'h00, 8'h0A,8'h2D,8'h0A,8'h01,8'h01,8'h01,8'h00}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       uip, done, alarm;

  int total = 0;
  int bad   = 0;
  int done_cnt  = 0;
  int alarm_cnt = 0;

  always #4 clk = ~clk;

  rtc_calendar u_rtc_calendar (
    .clk(clk), .rst(rst), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .uip_o(uip), .done_o(done), .alarm_o(alarm)
  );

  always @(negedge clk) begin
    if (done)  done_cnt++;
    if (alarm) alarm_cnt++;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic settle();
    repeat (TOTAL + 5) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] ctl, input logic [7:0] s, input logic [7:0] m,
                      input logic [7:0] h);
    wr(4'd11, ctl | 8'h80);
    wr(4'd0, s); wr(4'd2, m); wr(4'd4, h);
    wr(4'd11, ctl);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic [3:0] idx [7] = '{4'd0, 4'd2, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9};
    int d0, a0;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R11 reset state and read map
    rd(4'd0, d);  check("R1 sec", d, 8'h00);
    rd(4'd1, d);  check("R1 alarm sec", d, 8'h00);
    rd(4'd6, d);  check("R1 dow", d, 8'h01);
    rd(4'd7, d);  check("R1 dom", d, 8'h01);
    rd(4'd8, d);  check("R1 month", d, 8'h01);
    rd(4'd9, d);  check("R1 year", d, 8'h00);
    rd(4'd10, d); check("R1 status", d, 8'h00);
    rd(4'd11, d); check("R1 ctrl", d, 8'h02);
    rd(4'd13, d); check("R11 unused addr", d, 8'h00);
    check("R1 uip", {7'b0, uip}, 8'h00);

    // R11 control stores only bits 7,2,1
    wr(4'd11, 8'hFF);
    rd(4'd11, d); check("R11 ctrl mask", d, 8'h86);
    wr(4'd11, 8'h02);

    // R2 R3 R4 R5 vector walk
    for (int v = 0; v < NV; v++) begin
      logic [119:0] e;
      e = VEC[v];
      wr(4'd11, e[119:112] | 8'h80);
      for (int k = 0; k < 7; k++) wr(idx[k], e[111 - 8*k -: 8]);
      wr(4'd11, e[119:112]);
      pulse_tick();
      settle();
      for (int k = 0; k < 7; k++) begin
        rd(idx[k], d);
        check($sformatf("R2/R3/R4/R5 vec%0d field%0d", v, k), d, e[55 - 8*k -: 8]);
      end
    end

    // R7 timing: sec changes at cycle LEAD, busy lasts TOTAL cycles
    load(8'h02, 8'h10, 8'h00, 8'h00);
    @(negedge clk);
    rd_addr = 4'd0;
    d0 = done_cnt;
    @(negedge clk);
    tick = 1'b1;
    begin
      int hi;
      hi = 0;
      for (int k = 1; k <= TOTAL + 5; k++) begin
        @(negedge clk);
        tick = (k == 20);   // extra strobe while busy (R7: ignored)
        if (uip) hi++;
        if (k == LEAD + 1) check("R7 sec before change", rd_data, 8'h10);
        if (k == LEAD + 2) check("R7 sec after change", rd_data, 8'h11);
      end
      tick = 1'b0;
      check("R7 busy length", 8'(hi), 8'(TOTAL));
    end
    check("R8 one done per update", 8'(done_cnt - d0), 8'd1);
    settle();
    rd(4'd0, d); check("R7 busy strobe ignored", d, 8'h11);

    // R6 freeze ignores strobe
    wr(4'd11, 8'h82);
    begin
      int hi;
      hi = 0;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      for (int k = 0; k < TOTAL + 5; k++) begin
        @(negedge clk);
        if (uip) hi++;
      end
      check("R6 no busy in freeze", 8'(hi), 8'd0);
    end
    rd(4'd0, d); check("R6 sec unchanged", d, 8'h11);
    wr(4'd11, 8'h02);

    // R10 write during busy ignored, ctrl write accepted; R11 status reads busy
    load(8'h02, 8'h20, 8'h00, 8'h00);
    pulse_tick();
    repeat (20) @(negedge clk);
    rd(4'd10, d); check("R11 status busy", d, 8'h80);
    wr(4'd0, 8'h55);
    wr(4'd11, 8'h82);
    settle();
    rd(4'd0, d);  check("R10 write ignored while busy", d, 8'h21);
    rd(4'd11, d); check("R10 ctrl write while busy", d, 8'h82);
    wr(4'd11, 8'h02);

    // R9 alarm match
    load(8'h02, 8'h29, 8'h20, 8'h10);
    wr(4'd11, 8'h82);
    wr(4'd1, 8'h30); wr(4'd3, 8'h20); wr(4'd5, 8'h10);
    wr(4'd11, 8'h02);
    a0 = alarm_cnt;
    pulse_tick(); settle();
    check("R9 alarm match", 8'(alarm_cnt - a0), 8'd1);

    // R9 mismatch
    wr(4'd11, 8'h82); wr(4'd1, 8'h45); wr(4'd11, 8'h02);
    a0 = alarm_cnt;
    pulse_tick(); settle();
    check("R9 alarm mismatch", 8'(alarm_cnt - a0), 8'd0);

    // R9 don't care
    wr(4'd11, 8'h82);
    wr(4'd1, 8'hC0); wr(4'd3, 8'hFF); wr(4'd5, 8'hD3);
    wr(4'd11, 8'h02);
    a0 = alarm_cnt;
    pulse_tick(); settle();
    check("R9 alarm dont care", 8'(alarm_cnt - a0), 8'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule